// File: doc/BRIEF.md
# Dual-Format Serial Register Port

This block is the slave side of a chip's control port. A host loads a sixteen-entry, eight-bit register file through it, using either I2C or SPI. The block starts in I2C mode after reset. The first time the shared address/select pin goes from high to low, the block switches to SPI, and it stays in SPI until the next reset. The host's activity does not need to follow any other clock in the chip. All pins pass through synchronizers into the system clock, and edges are detected after that.

Every write frame has the same shape: a chip-address byte, then a pointer byte, then any number of data bytes. The pointer byte has two parts. Its low four bits give the register index. Bit 7 sets auto-increment, which lets the host write a block of registers in one frame. In I2C mode the host can also read registers back: it issues a repeated start, then sends the address with the read bit set. The whole register file is available to the rest of the chip. One bit of it is also brought out on its own pin as the control-port enable flag.

Top module: `regport_top`

## Requirements
- R1: When reset is released, all registers read 0x00, the pointer is 0x00, the block is in I2C mode, SDA is released (`sda_oe` = 0) and `cpen_o` = 0.
- R2: In I2C mode the block answers the 7-bit address {1,0,0,1,1, `ad1_i`, `ad0_cs_i`}, which is 0x9A with W for `ad1_i`=0 and `ad0_cs_i`=1. It acknowledges by pulling SDA low during the ninth clock of the address byte and of every byte written after it.
- R3: An I2C frame whose address does not match gets no acknowledge, and it changes no register until the next start condition.
- R4: In the pointer byte, bit 7 is the auto-increment flag and bits 3:0 are the register index. Bits 6:4 are ignored. A frame that ends after its pointer byte writes no register.
- R5: With the auto-increment flag at 0, every data byte in the frame goes to the same register, and the last byte written stays there.
- R6: With the auto-increment flag at 1, the index moves up by one after each data byte, and it wraps from 15 to 0.
- R7: An I2C read (repeated start, then the address with R) returns the register at the pointer, MSB first. The index advances after each byte only when the auto-increment flag is 1. After the master's NACK, SDA is released.
- R8: The first falling edge on `ad0_cs_i` selects SPI mode, and that mode holds until reset. In SPI mode the block never drives SDA and ignores I2C traffic.
- R9: An SPI frame runs while `ad0_cs_i` is low. Bits are sampled MSB first on each rising edge of `scl_i` from `sdi_i`. The frame carries the chip byte {1,0,0,1,1, `ad1_i`, 0, W=0} (0x98 for `ad1_i`=0), then the pointer byte, then data bytes. The frame ends when `ad0_cs_i` rises.
- R10: An SPI frame whose chip byte does not match, or whose R/W bit is 1, writes no register.
- R11: `cpen_o` follows bit 7 of register 2.
- R12: Registers change only in the cycle after a data byte has been received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | I2C clock in I2C mode, or serial clock in SPI mode |
| sda_i | input | 1 | I2C data line as seen at the pin |
| sda_oe | output | 1 | When 1, pull SDA low (open-drain) |
| ad0_cs_i | input | 1 | Address bit 0 in I2C mode, or active-low select in SPI mode |
| ad1_i | input | 1 | Address bit 1 |
| sdi_i | input | 1 | SPI serial data in |
| regs_o | output | 128 | Register file, with register n at bits [8n+7:8n] |
| cpen_o | output | 1 | Control-port enable flag (register 2, bit 7) |

## Verification
The hardest states to reach are the read handover and the mode switch. In the read handover, a pointer-only write is followed by a repeated start and a read that crosses the 15-to-0 wrap, so the pointer has to survive the restart and then move only after each byte has been shifted out. The mode switch has to come after real I2C traffic has already changed the registers. The stimulus writes 0x8E with no data, restarts, reads two bytes, and expects the values that an earlier block write placed in registers 14 and 15. Only after that does it drop the select pin for the first time. Once the block is in SPI mode, a complete I2C write is sent and must get no acknowledge and leave its target register unchanged. A reset then shows that I2C mode has come back.

// File: rtl/regport_pkg.sv
package regport_pkg;
  typedef enum logic [2:0] {F_IDLE, F_ADDR, F_PTR, F_DATA, F_READ, F_SKIP} frm_state_t;
  typedef enum logic [2:0] {I_IDLE, I_RX, I_ACK, I_TX, I_RACK} i2c_state_t;
endpackage

// File: rtl/regport_sync.sv
module regport_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/regport_i2c.sv
module regport_i2c
  import regport_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       scl_s,
  input  logic       sda_s,
  input  logic       accept,
  input  logic [7:0] rd_data,
  output logic       start,
  output logic       stop,
  output logic       bvld,
  output logic [7:0] bdata,
  output logic       rd_adv,
  output logic       sda_oe
);
  i2c_state_t st;
  logic       scl_q, sda_q;
  logic [2:0] bcnt;
  logic [7:0] sh;
  logic       full_q, ack_q, rw_q, first_q, nack_q;
  logic       scl_rise, scl_fall;

  assign scl_rise = ~scl_q & scl_s;
  assign scl_fall = scl_q & ~scl_s;
  assign start    = en & scl_q & scl_s & sda_q & ~sda_s;
  assign stop     = en & scl_q & scl_s & ~sda_q & sda_s;
  assign bvld     = en & (st == I_RX) & scl_rise & (bcnt == 3'd7);
  assign bdata    = {sh[6:0], sda_s};
  assign rd_adv   = en & (st == I_TX) & scl_fall & (bcnt == 3'd7);
  assign sda_oe   = (st == I_ACK) | ((st == I_TX) & ~sh[7]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= I_IDLE; scl_q <= 1'b1; sda_q <= 1'b1; bcnt <= '0; sh <= '0;
      full_q <= 1'b0; ack_q <= 1'b0; rw_q <= 1'b0; first_q <= 1'b0; nack_q <= 1'b0;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
      if (!en) begin
        st <= I_IDLE;
      end else if (start) begin
        st <= I_RX; bcnt <= '0; full_q <= 1'b0; first_q <= 1'b1;
      end else if (stop) begin
        st <= I_IDLE;
      end else begin
        case (st)
          I_RX: begin
            if (scl_rise) begin
              sh   <= {sh[6:0], sda_s};
              bcnt <= bcnt + 3'd1;
              if (bcnt == 3'd7) begin
                full_q <= 1'b1;
                ack_q  <= accept;
                rw_q   <= first_q & sda_s;
              end
            end else if (scl_fall && full_q) begin
              full_q  <= 1'b0;
              first_q <= 1'b0;
              st      <= ack_q ? I_ACK : I_IDLE;
            end
          end
          I_ACK: if (scl_fall) begin
            bcnt <= '0;
            if (rw_q) begin
              st <= I_TX; sh <= rd_data;
            end else begin
              st <= I_RX;
            end
          end
          I_TX: if (scl_fall) begin
            if (bcnt == 3'd7) st <= I_RACK;
            else begin
              sh   <= {sh[6:0], 1'b1};
              bcnt <= bcnt + 3'd1;
            end
          end
          I_RACK: begin
            if (scl_rise) nack_q <= sda_s;
            if (scl_fall) begin
              if (nack_q) st <= I_IDLE;
              else begin
                st <= I_TX; sh <= rd_data; bcnt <= '0;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/regport_spi.sv
module regport_spi (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       cs_s,
  input  logic       cs_fall,
  input  logic       cs_rise,
  input  logic       scl_s,
  input  logic       sdi_s,
  output logic       start,
  output logic       stop,
  output logic       bvld,
  output logic [7:0] bdata
);
  logic       scl_q;
  logic [2:0] bcnt;
  logic [6:0] sh;
  logic       scl_rise;

  assign scl_rise = ~scl_q & scl_s;
  assign start    = en & cs_fall;
  assign stop     = en & cs_rise;
  assign bvld     = en & ~cs_s & scl_rise & (bcnt == 3'd7);
  assign bdata    = {sh, sdi_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b0; bcnt <= '0; sh <= '0;
    end else begin
      scl_q <= scl_s;
      if (cs_fall) bcnt <= '0;
      else if (!cs_s && scl_rise) begin
        sh   <= {sh[5:0], sdi_s};
        bcnt <= bcnt + 3'd1;
      end
    end
  end
endmodule

// File: rtl/regport_frame.sv
module regport_frame
  import regport_pkg::*;
#(
  parameter int NREG = 16,
  parameter logic [4:0] ID_HI = 5'b10011,
  localparam int AW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            stop,
  input  logic            bvld,
  input  logic [7:0]      bdata,
  input  logic            is_spi,
  input  logic            ad1,
  input  logic            ad0,
  input  logic            rd_adv,
  output logic            accept,
  output logic [7:0]      rd_data,
  output logic [NREG*8-1:0] regs_o
);
  frm_state_t     st;
  logic           incr_q;
  logic [AW-1:0]  idx_q;
  logic [7:0]     regs [NREG];
  logic           match;

  assign match   = (bdata[7:1] == {ID_HI, ad1, ad0});
  assign rd_data = regs[idx_q];

  always_comb begin
    case (st)
      F_ADDR:         accept = match & ~(is_spi & bdata[0]);
      F_PTR, F_DATA:  accept = 1'b1;
      default:        accept = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= F_IDLE; incr_q <= 1'b0; idx_q <= '0;
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (start) begin
      st <= F_ADDR;
    end else if (stop) begin
      st <= F_IDLE;
    end else if (bvld) begin
      case (st)
        F_ADDR: st <= !accept ? F_SKIP : (bdata[0] ? F_READ : F_PTR);
        F_PTR: begin
          incr_q <= bdata[7];
          idx_q  <= bdata[AW-1:0];
          st     <= F_DATA;
        end
        F_DATA: begin
          regs[idx_q] <= bdata;
          if (incr_q) idx_q <= idx_q + AW'(1);
        end
        default: ;
      endcase
    end else if (rd_adv && st == F_READ && incr_q) begin
      idx_q <= idx_q + AW'(1);
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign regs_o[g*8 +: 8] = regs[g];
  end
endmodule

// File: rtl/regport_top.sv
module regport_top #(
  parameter int NREG = 16,
  parameter logic [4:0] ID_HI = 5'b10011,
  parameter int CPEN_REG = 2,
  parameter int CPEN_BIT = 7,
  localparam int RW = NREG * 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  input  logic          ad0_cs_i,
  input  logic          ad1_i,
  input  logic          sdi_i,
  output logic [RW-1:0] regs_o,
  output logic          cpen_o
);
  logic ad1_s, scl_s, sda_s, cs_s, sdi_s;
  logic cs_q, cs_fall, cs_rise, spi_mode, use_spi;
  logic i_start, i_stop, i_bvld, i_rdadv;
  logic s_start, s_stop, s_bvld;
  logic [7:0] i_bdata, s_bdata, f_bdata, rd_data;
  logic f_start, f_stop, f_bvld, accept;

  regport_sync #(.W(5), .STAGES(2), .RST_VAL(5'b01110)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({ad1_i, scl_i, sda_i, ad0_cs_i, sdi_i}),
    .q({ad1_s, scl_s, sda_s, cs_s, sdi_s}));

  assign cs_fall = cs_q & ~cs_s;
  assign cs_rise = ~cs_q & cs_s;
  assign use_spi = spi_mode | cs_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q <= 1'b1; spi_mode <= 1'b0;
    end else begin
      cs_q <= cs_s;
      if (cs_fall) spi_mode <= 1'b1;
    end
  end

  regport_i2c u_i2c (
    .clk(clk), .rst_n(rst_n), .en(~use_spi), .scl_s(scl_s), .sda_s(sda_s),
    .accept(accept), .rd_data(rd_data), .start(i_start), .stop(i_stop),
    .bvld(i_bvld), .bdata(i_bdata), .rd_adv(i_rdadv), .sda_oe(sda_oe));

  regport_spi u_spi (
    .clk(clk), .rst_n(rst_n), .en(use_spi), .cs_s(cs_s), .cs_fall(cs_fall),
    .cs_rise(cs_rise), .scl_s(scl_s), .sdi_s(sdi_s), .start(s_start),
    .stop(s_stop), .bvld(s_bvld), .bdata(s_bdata));

  assign f_start = i_start | s_start;
  assign f_stop  = i_stop | s_stop;
  assign f_bvld  = i_bvld | s_bvld;
  assign f_bdata = use_spi ? s_bdata : i_bdata;

  regport_frame #(.NREG(NREG), .ID_HI(ID_HI)) u_frame (
    .clk(clk), .rst_n(rst_n), .start(f_start), .stop(f_stop), .bvld(f_bvld),
    .bdata(f_bdata), .is_spi(use_spi), .ad1(ad1_s), .ad0(cs_s),
    .rd_adv(i_rdadv), .accept(accept), .rd_data(rd_data), .regs_o(regs_o));

  assign cpen_o = regs_o[CPEN_REG*8 + CPEN_BIT];
endmodule

// File: rtl/regport_chk.sv
module regport_chk #(
  parameter int W = 128
) (
  input logic         clk,
  input logic         rst_n,
  input logic         spi_mode,
  input logic         cs_fall,
  input logic         sda_oe,
  input logic         byte_vld,
  input logic [W-1:0] regs_o
);
  a_r8_spi_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    spi_mode |=> spi_mode);

  a_r8_cs_fall_selects: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> spi_mode);

  a_r8_spi_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    spi_mode |-> !sda_oe);

  a_r12_regs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_vld |=> $stable(regs_o));
endmodule

bind regport_top regport_chk #(.W(NREG*8)) u_chk (
  .clk(clk), .rst_n(rst_n), .spi_mode(spi_mode), .cs_fall(cs_fall),
  .sda_oe(sda_oe), .byte_vld(f_bvld), .regs_o(regs_o));

// File: tb/regport_top_tb.sv
module regport_top_tb;
  localparam int CLK_NS = 10;
  localparam int H = 8;

  typedef struct packed {
    logic [7:0] ab;
    logic [7:0] pb;
    logic [7:0] db;
    logic [3:0] idx;
    logic [7:0] exp_val;
    logic [2:0] exp_ack;
  } vec_t;

  localparam vec_t VEC [5] = '{
    '{8'h9A, 8'h03, 8'hA5, 4'd3, 8'hA5, 3'b111},  // R2
    '{8'h9A, 8'h71, 8'h3C, 4'd1, 8'h3C, 3'b111},  // R4 reserved bits
    '{8'h98, 8'h04, 8'hEE, 4'd4, 8'h00, 3'b000},  // R3 wrong ad0
    '{8'h9A, 8'h02, 8'h80, 4'd2, 8'h80, 3'b111},  // R11
    '{8'h1A, 8'h06, 8'h55, 4'd6, 8'h00, 3'b000}   // R3 wrong upper bits
  };

  logic clk = 0, rst_n = 0;
  logic scl = 1, m_sda = 1, cs = 1, ad1 = 0, sdi = 0;
  logic sda_oe, cpen;
  logic [127:0] regs;
  wire sda_line = m_sda & ~sda_oe;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;

  regport_top u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .ad0_cs_i(cs), .ad1_i(ad1), .sdi_i(sdi), .regs_o(regs), .cpen_o(cpen));

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #3;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] rg(input int i);
    return regs[i*8 +: 8];
  endfunction

  task automatic i2c_start();
    m_sda = 1; scl = 1; tick(H); m_sda = 0; tick(H); scl = 0; tick(H);
  endtask

  task automatic i2c_rstart();
    m_sda = 1; tick(H); scl = 1; tick(H); m_sda = 0; tick(H); scl = 0; tick(H);
  endtask

  task automatic i2c_stop();
    m_sda = 0; tick(H); scl = 1; tick(H); m_sda = 1; tick(H);
  endtask

  task automatic i2c_wbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; tick(H); scl = 1; tick(H); scl = 0;
    end
    m_sda = 1; tick(H); scl = 1; tick(H); ack = ~sda_line; scl = 0;
  endtask

  task automatic i2c_rbyte(input logic nack, output logic [7:0] b);
    m_sda = 1;
    for (int i = 7; i >= 0; i--) begin
      tick(H); scl = 1; tick(H); b[i] = sda_line; scl = 0;
    end
    m_sda = nack; tick(H); scl = 1; tick(H); scl = 0; tick(1); m_sda = 1;
  endtask

  task automatic i2c_wr(input logic [7:0] ab, input logic [7:0] pb,
                        input logic [7:0] db, output logic [2:0] acks);
    i2c_start();
    i2c_wbyte(ab, acks[2]);
    i2c_wbyte(pb, acks[1]);
    i2c_wbyte(db, acks[0]);
    i2c_stop();
    tick(H);
  endtask

  task automatic spi_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sdi = b[i]; tick(H); scl = 1; tick(H); scl = 0;
    end
  endtask

  task automatic spi_frame4(input logic [7:0] a, input logic [7:0] p,
                            input logic [7:0] d0, input logic [7:0] d1);
    scl = 0; tick(H); cs = 0; tick(H);
    spi_byte(a); spi_byte(p); spi_byte(d0); spi_byte(d1);
    tick(H); cs = 1; tick(2*H);
  endtask

  task automatic finish_up();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      finish_up();
    end
  end

  initial begin
    logic [2:0] acks;
    logic a0, a1, a2;
    logic [7:0] b0, b1;
    tick(5); rst_n = 1; tick(5);

    check("R1 regs after reset", {31'd0, regs == '0}, 32'd1);
    check("R1 cpen after reset", {31'd0, cpen}, 32'd0);
    check("R1 sda released", {31'd0, sda_oe}, 32'd0);

    for (int k = 0; k < 5; k++) begin
      i2c_wr(VEC[k].ab, VEC[k].pb, VEC[k].db, acks);
      check($sformatf("R2/R3 ack vec%0d", k), {29'd0, acks}, {29'd0, VEC[k].exp_ack});
      check($sformatf("R2/R3/R4 reg vec%0d", k), {24'd0, rg(VEC[k].idx)}, {24'd0, VEC[k].exp_val});
    end
    check("R11 cpen set", {31'd0, cpen}, 32'd1);

    // R6 block write with wrap 15 -> 0
    i2c_start(); i2c_wbyte(8'h9A, a0); i2c_wbyte(8'h8E, a0);
    i2c_wbyte(8'h11, a0); i2c_wbyte(8'h22, a0); i2c_wbyte(8'h33, a1); i2c_stop(); tick(H);
    check("R6 reg14", {24'd0, rg(14)}, 32'h11);
    check("R6 reg15", {24'd0, rg(15)}, 32'h22);
    check("R6 wrap reg0", {24'd0, rg(0)}, 32'h33);

    // R5 fixed pointer
    i2c_start(); i2c_wbyte(8'h9A, a0); i2c_wbyte(8'h05, a0);
    i2c_wbyte(8'h44, a0); i2c_wbyte(8'h55, a0); i2c_stop(); tick(H);
    check("R5 reg5 last wins", {24'd0, rg(5)}, 32'h55);
    check("R5 reg6 untouched", {24'd0, rg(6)}, 32'h00);

    // R7 read with increment across restart
    i2c_start(); i2c_wbyte(8'h9A, a0); i2c_wbyte(8'h8E, a1);
    i2c_rstart(); i2c_wbyte(8'h9B, a2);
    i2c_rbyte(1'b0, b0); i2c_rbyte(1'b1, b1); i2c_stop(); tick(H);
    check("R7 read addr ack", {31'd0, a2}, 32'd1);
    check("R7 read byte0", {24'd0, b0}, 32'h11);
    check("R7 read byte1", {24'd0, b1}, 32'h22);
    check("R7 sda released after nack", {31'd0, sda_oe}, 32'd0);
    check("R4 pointer-only frame kept reg14", {24'd0, rg(14)}, 32'h11);

    // R7 read without increment
    i2c_start(); i2c_wbyte(8'h9A, a0); i2c_wbyte(8'h05, a0);
    i2c_rstart(); i2c_wbyte(8'h9B, a0);
    i2c_rbyte(1'b0, b0); i2c_rbyte(1'b1, b1); i2c_stop(); tick(H);
    check("R7 fixed read byte0", {24'd0, b0}, 32'h55);
    check("R7 fixed read byte1", {24'd0, b1}, 32'h55);

    // R8/R9 first CS fall selects SPI; block write regs 7,8
    spi_frame4(8'h98, 8'h87, 8'h66, 8'h77);
    check("R9 spi reg7", {24'd0, rg(7)}, 32'h66);
    check("R9 spi reg8", {24'd0, rg(8)}, 32'h77);

    // R10 read bit set, then wrong chip byte
    spi_frame4(8'h99, 8'h09, 8'h12, 8'h13);
    check("R10 rw=1 ignored", {24'd0, rg(9)}, 32'h00);
    spi_frame4(8'hB8, 8'h09, 8'h12, 8'h13);
    check("R10 wrong chip ignored", {24'd0, rg(9)}, 32'h00);

    // R8 I2C traffic ignored in SPI mode
    i2c_wr(8'h9A, 8'h0A, 8'h5A, acks);
    check("R8 no ack in spi mode", {29'd0, acks}, 32'd0);
    check("R8 reg10 untouched", {24'd0, rg(10)}, 32'h00);

    // R1 reset returns to I2C mode
    scl = 1; tick(H); rst_n = 0; tick(3); rst_n = 1; tick(5);
    check("R1 regs cleared", {31'd0, regs == '0}, 32'd1);
    i2c_wr(8'h9A, 8'h0B, 8'h77, acks);
    check("R1 i2c ack after reset", {29'd0, acks}, 32'd7);
    check("R1 reg11 after reset", {24'd0, rg(11)}, 32'h77);

    done = 1;
    finish_up();
  end
endmodule